// File: doc/BRIEF.md
# T1 Extended Superframe Transmit Formatter

This block turns parallel channel octets into the serial bit stream of a T1/J1 extended superframe. Each multiframe holds 24 frames. Each frame is one overhead bit followed by 24 eight-bit channels. The overhead bit of a frame comes from one of three sources, chosen by the frame number:
- a bit from a serial data-link source;
- one bit of the CRC-6 computed over the previous multiframe;
- one bit of the fixed alignment word.

In four of the frames, the last bit of every channel carries one of the channel's four signaling bits in place of data.

The block advances one bit position for each cycle in which the bit-rate enable is high. It takes a channel octet, with that channel's four signaling bits, through a ready/valid beat at the first bit of each channel. If no octet is offered at that moment, the block sends an all-ones idle octet. The serial output is registered and comes with a marker that is high while the overhead bit of frame 1 is on the line. A line encoder downstream consumes the output.

Top module: `esf_tx_formatter`

## Requirements
- R1: The stream repeats every 24 frames of 193 bit periods. tx_mf_start is high exactly while the overhead bit of frame 1 is on tx_bit, which is once every 4632 enabled bits. The first enabled bit after reset is that overhead bit.
- R2: The overhead bits of frames 4, 8, 12, 16, 20 and 24 are 0, 0, 1, 0, 1, 1 in that order.
- R3: The overhead bits of frames 2, 6, 10, 14, 18 and 22 carry check bits C1 to C6 of the previous multiframe, in that order. During the first multiframe after reset they are all 0.
- R4: The check value is the remainder of the multiframe's 4632 bits, taken in line order and multiplied by x^6, divided by x^6 + x + 1. Every overhead bit counts as 1 in this calculation, and C1 is the coefficient of x^5.
- R5: The overhead bit of each odd-numbered frame is the value on dl_bit at the enabled edge that sends it. dl_strobe is high in exactly that cycle and in no other.
- R6: ch_ready is high only in a cycle with bit_en high at the first bit of a channel. On that edge the octet on ch_data is taken when ch_valid is high, and it is sent bit 7 (channel bit 1) first.
- R7: When ch_valid is low at a channel start, the channel sends 8'hFF.
- R8: In frames 6, 12, 18 and 24, channel bit 8 of every channel is replaced by sig_abcd[3], [2], [1] and [0] respectively (A, B, C, D), sampled at the channel start. Channel bits 1 to 7 still carry the octet.
- R9: In every other frame, all 8 channel bits carry the octet and sig_abcd has no effect on tx_bit.
- R10: While bit_en is low, tx_bit and tx_mf_start hold and no position counter moves.
- R11: After reset, tx_bit and tx_mf_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-rate enable; one line bit per high cycle |
| ch_data | input | 8 | Channel octet, bit 7 sent first |
| ch_valid | input | 1 | ch_data holds an octet |
| ch_ready | output | 1 | Octet taken at this edge when ch_valid is high |
| sig_abcd | input | 4 | Signaling bits A..D of the channel, A at bit 3 |
| dl_bit | input | 1 | Serial data-link bit |
| dl_strobe | output | 1 | dl_bit is consumed at this edge |
| tx_bit | output | 1 | Serial line bit |
| tx_mf_start | output | 1 | High during the overhead bit of frame 1 |

## Verification
If a frame or bit counter goes wrong, the position of tx_mf_start and the ch_ready strobes drift within one frame, and the fixed alignment word appears in the wrong overhead bits within four frames. An error in the running check register cannot be seen until the next multiframe, where it shows in the C1 to C6 bits of frames 2 to 22. A misrouted signaling lane or a slip in the held octet changes channel bits in the very next channel.

// File: rtl/esf_pkg.sv
package esf_pkg;
  localparam int FRAMES  = 24;
  localparam int CHANS   = 24;
  localparam int CH_BITS = 8;
  localparam int CRC_W   = 6;
  localparam int SIG_W   = 4;
  localparam int FRAME_W = $clog2(FRAMES);
  localparam int CHAN_W  = $clog2(CHANS);
  localparam int BIT_W   = $clog2(CH_BITS);

  // Serial CRC-6 step, generator x^6 + x + 1, highest order first.
  function automatic logic [CRC_W-1:0] crc6_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
  endfunction

  // Alignment word element k (0..5) of 0,0,1,0,1,1.
  function automatic logic align_bit(input logic [2:0] k);
    logic [5:0] word;
    word = 6'b110100;
    return word[k];
  endfunction

  // Signaling lane for a frame index: {active, lane}; lane 0 = A.
  function automatic logic [2:0] sig_lane(input logic [FRAME_W-1:0] f);
    case (f)
      FRAME_W'(5):  return 3'b100;
      FRAME_W'(11): return 3'b101;
      FRAME_W'(17): return 3'b110;
      FRAME_W'(23): return 3'b111;
      default:      return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/esf_timebase.sv
module esf_timebase
  import esf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  output logic [FRAME_W-1:0] frame,
  output logic [BIT_W-1:0]   bit_cnt,
  output logic               in_fbit,
  output logic               chan_start,
  output logic               mf_last
);
  localparam logic [BIT_W-1:0]   LAST_BIT   = BIT_W'(CH_BITS - 1);
  localparam logic [CHAN_W-1:0]  LAST_CHAN  = CHAN_W'(CHANS - 1);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES - 1);

  logic [CHAN_W-1:0] chan;
  logic              chan_end;

  assign chan_end   = !in_fbit && bit_cnt == LAST_BIT;
  assign chan_start = !in_fbit && bit_cnt == '0;
  assign mf_last    = chan_end && chan == LAST_CHAN && frame == LAST_FRAME;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      chan    <= '0;
      bit_cnt <= '0;
      in_fbit <= 1'b1;
    end else if (bit_en) begin
      if (in_fbit) begin
        in_fbit <= 1'b0;
        chan    <= '0;
        bit_cnt <= '0;
      end else if (chan_end) begin
        bit_cnt <= '0;
        if (chan == LAST_CHAN) begin
          in_fbit <= 1'b1;
          frame   <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
        end else begin
          chan <= chan + 1'b1;
        end
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assert_frame_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame <= LAST_FRAME && chan <= LAST_CHAN);
  assert_wrap_to_fbit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mf_last) |=> (in_fbit && frame == '0));
  assert_counters_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(frame) && $stable(bit_cnt) && $stable(in_fbit)));
endmodule

// File: rtl/esf_crc6.sv
module esf_crc6
  import esf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             crc_in,
  input  logic             mf_last,
  output logic [CRC_W-1:0] crc_prev
);
  logic [CRC_W-1:0] crc_run;
  logic [CRC_W-1:0] crc_nxt;

  assign crc_nxt = crc6_step(crc_run, crc_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_run  <= '0;
      crc_prev <= '0;
    end else if (bit_en) begin
      if (mf_last) begin
        crc_prev <= crc_nxt;
        crc_run  <= '0;
      end else begin
        crc_run <= crc_nxt;
      end
    end
  end

  assert_crc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(crc_run) && $stable(crc_prev)));
  assert_crc_result_only_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && mf_last) |=> $stable(crc_prev));
endmodule

// File: rtl/esf_tx_formatter.sv
module esf_tx_formatter
  import esf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic [7:0]   ch_data,
  input  logic         ch_valid,
  output logic         ch_ready,
  input  logic [3:0]   sig_abcd,
  input  logic         dl_bit,
  output logic         dl_strobe,
  output logic         tx_bit,
  output logic         tx_mf_start
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CH_BITS - 1);

  logic [FRAME_W-1:0] frame;
  logic [BIT_W-1:0]   bit_cnt;
  logic               in_fbit;
  logic               chan_start;
  logic               mf_last;
  logic [CRC_W-1:0]   crc_prev;
  logic [CH_BITS-1:0] hold_byte;
  logic [SIG_W-1:0]   hold_sig;
  logic [CH_BITS-1:0] byte_now;
  logic [2:0]         fsel;
  logic [2:0]         lane;
  logic               fbit_val;
  logic               chan_val;
  logic               line_bit;
  logic               crc_in;

  esf_timebase u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .frame      (frame),
    .bit_cnt    (bit_cnt),
    .in_fbit    (in_fbit),
    .chan_start (chan_start),
    .mf_last    (mf_last)
  );

  esf_crc6 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .crc_in   (crc_in),
    .mf_last  (mf_last),
    .crc_prev (crc_prev)
  );

  assign ch_ready  = bit_en && chan_start;
  assign dl_strobe = bit_en && in_fbit && !frame[0];
  assign byte_now  = ch_valid ? ch_data : '1;
  assign fsel      = frame[FRAME_W-1:2];
  assign lane      = sig_lane(frame);

  // Overhead bit: even index = data link, index%4==1 = check, index%4==3 = alignment.
  always_comb begin
    if (!frame[0])     fbit_val = dl_bit;
    else if (!frame[1]) fbit_val = crc_prev[3'd5 - fsel];
    else               fbit_val = align_bit(fsel);
  end

  always_comb begin
    if (chan_start)
      chan_val = byte_now[CH_BITS-1];
    else if (bit_cnt == LAST_BIT && lane[2])
      chan_val = hold_sig[2'd3 - lane[1:0]];
    else
      chan_val = hold_byte[LAST_BIT - bit_cnt];
  end

  assign line_bit = in_fbit ? fbit_val : chan_val;
  assign crc_in   = in_fbit ? 1'b1 : chan_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte   <= '1;
      hold_sig    <= '0;
      tx_bit      <= 1'b0;
      tx_mf_start <= 1'b0;
    end else if (bit_en) begin
      tx_bit      <= line_bit;
      tx_mf_start <= in_fbit && frame == '0;
      if (chan_start) begin
        hold_byte <= byte_now;
        hold_sig  <= sig_abcd;
      end
    end
  end

  assert_ready_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready |=> !ch_ready);
  assert_ready_dl_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_ready && dl_strobe));
  assert_dl_on_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dl_strobe |=> tx_bit == $past(dl_bit));
  assert_mf_marker_place_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mf_start) |-> (frame == '0 && chan_start));
  assert_line_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_mf_start)));
endmodule

// File: tb/sim_esf_tx_formatter.sv
module sim_esf_tx_formatter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] ch_data = '0;
  logic       ch_valid = 1'b0;
  logic [3:0] sig_abcd = '0;
  logic       dl_bit = 1'b0;
  logic       ch_ready, dl_strobe, tx_bit, tx_mf_start;

  int tests = 0;
  int fails = 0;

  int       frame = 0;
  int       slot = 0;
  logic [7:0] hbyte = '1;
  logic [3:0] hsig = '0;
  logic [6:0] rem = '0;
  logic [5:0] chk = '0;
  logic     exp_bit = 1'b0;
  logic     exp_mf = 1'b0;
  string    tag = "R11";

  always #2 clk = ~clk;

  esf_tx_formatter u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ch_data(ch_data),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .sig_abcd(sig_abcd),
    .dl_bit(dl_bit), .dl_strobe(dl_strobe), .tx_bit(tx_bit),
    .tx_mf_start(tx_mf_start)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      if (fails < 25)
        $display("FAIL %s %s frame=%0d slot=%0d actual=%0b expected=%0b", req, what, frame, slot, act, exp);
    end
  endtask

  // Remainder division with the message shifted in bit by bit (augmented form).
  function automatic logic [6:0] div_in(input logic [6:0] r, input logic b);
    logic [6:0] t;
    t = {r[5:0], b};
    if (t[6]) t = t ^ 7'h43;
    return t;
  endfunction

  function automatic logic ovh_bit(input int f, input logic dl, input logic [5:0] c);
    logic [0:5] fas;
    fas = 6'b001011;
    if (f % 2 == 0) return dl;
    if (f % 4 == 1) return c[5 - f/4];
    return fas[f/4];
  endfunction

  task automatic step(input logic be, input logic v, input logic [7:0] d,
                      input logic [3:0] s, input logic dl);
    int    b;
    logic  nb;
    logic [7:0] byt;
    @(negedge clk);
    check(tag, tx_bit, exp_bit, "tx_bit");
    check(be ? "R1" : "R10", tx_mf_start, exp_mf, "tx_mf_start");
    bit_en = be; ch_valid = v; ch_data = d; sig_abcd = s; dl_bit = dl;
    #1;
    check("R6", ch_ready, be && slot > 0 && (slot - 1) % 8 == 0, "ch_ready");
    check("R5", dl_strobe, be && slot == 0 && frame % 2 == 0, "dl_strobe");
    if (!be) begin
      tag = "R10";
    end else begin
      if (slot == 0) begin
        nb = ovh_bit(frame, dl, chk);
        tag = (frame % 2 == 0) ? "R5" : ((frame % 4 == 1) ? "R3 R4" : "R2");
        rem = div_in(rem, 1'b1);
      end else begin
        b = (slot - 1) % 8;
        if (b == 0) begin
          byt = v ? d : 8'hFF;
          hbyte = byt; hsig = s;
        end
        if (b == 7 && frame % 6 == 5) begin
          nb = hsig[3 - frame/6];
          tag = "R8";
        end else begin
          nb = hbyte[7 - b];
          tag = (hbyte == 8'hFF) ? "R7" : ((frame % 6 == 5) ? "R8" : "R9");
        end
        rem = div_in(rem, nb);
      end
      exp_bit = nb;
      exp_mf = (slot == 0 && frame == 0);
      if (slot == 192) begin
        slot = 0;
        if (frame == 23) begin
          frame = 0;
          for (int k = 0; k < 6; k++) rem = div_in(rem, 1'b0);
          chk = rem[5:0];
          rem = '0;
        end else frame++;
      end else slot++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0E5F));
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11", tx_bit, 1'b0, "tx_bit reset");
    check("R11", tx_mf_start, 1'b0, "tx_mf_start reset");
    check("R6", ch_ready, 1'b0, "ch_ready reset");
    rst_n = 1'b1;
    // Directed: full-rate multiframe, all octets valid (first multiframe sends zero check bits, R3)
    for (int i = 0; i < 4632; i++)
      step(1'b1, 1'b1, 8'($urandom), 4'($urandom), 1'($urandom));
    // Directed: idle multiframe, no octet offered (R7), signaling still inserted (R8)
    for (int i = 0; i < 4632; i++)
      step(1'b1, 1'b0, 8'($urandom), 4'($urandom), 1'($urandom));
    // Directed: long enable gap (R10)
    for (int i = 0; i < 40; i++)
      step(1'b0, 1'b1, 8'($urandom), 4'($urandom), 1'($urandom));
    // Random enable and valid over two more multiframes
    for (int i = 0; i < 16000; i++)
      step(($urandom % 10) < 6, ($urandom % 4) != 0, 8'($urandom), 4'($urandom), 1'($urandom));
    // Directed: alternating octet patterns at full rate, then drain to next check bits
    for (int i = 0; i < 9300; i++)
      step(1'b1, 1'b1, (i % 2) ? 8'h00 : 8'hA5, 4'($urandom), 1'($urandom));
    step(1'b0, 1'b0, 8'h00, 4'h0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule